// File: doc/BRIEF.md
# Mode-Selectable Programmable Frequency Divider

This block divides its clock by a programmable integer n. The count is mixed-radix. The lowest section has a selectable modulus M of 2, 4, 5, 8 or 10. Above it sit three BCD decades, and above those a small top digit that weighs thousands. The division ratio is n = M × (1000·T + 100·D4 + 10·D3 + D2) + D1, where T is the top digit, D4 to D2 are the decades and D1 is the low digit. This gives every integer from 3 to 15 999.

Each time the count runs out, the block reloads all sections from a 16-bit preset word and raises its output for one clock. With the latch input held high the output acts as a timer: it stays high from the first pulse until latch is sampled low, and the count keeps running while the output is held. The mode selector also offers a fixed divide-by-10 000 setting and a master-preset state. The master-preset state parks the counter and keeps the output low.

Top module: `modn_divider`

## Requirements
- R1: For an in-range n (3 to 15 999), rising edges of `out_o` are exactly n clock cycles apart, with n = M × (1000·T + 100·D4 + 10·D3 + D2) + D1.
- R2: `sel_i` codes: 3'b111 gives M=2, 3'b110 gives M=4, 3'b001 gives M=5, 3'b101 gives M=8, 3'b011 gives M=10, and 3'b010 gives divide-by-10 000. 3'b000 and 3'b100 give the master-preset state.
- R3: Preset fields: D2 = `jam_i[7:4]`, D3 = `jam_i[11:8]`, D4 = `jam_i[15:12]`. The low nibble `jam_i[3:0]` is split by mode. D1 takes its lowest k bits and T takes the bits above them, with k = 1, 2, 3, 3, 4 for M = 2, 4, 5, 8, 10. T is therefore 0 when M = 10.
- R4: With `latch_i` low, each output pulse lasts exactly one clock cycle.
- R5: Timer mode. While `latch_i` is high, `out_o` stays high from the first pulse onward. It drops at the first edge at which `latch_i` is sampled low. Counting goes on throughout, so later pulses keep their original spacing.
- R6: Master-preset state. In this state `out_o` is low and the count is held. On entry to a counting mode, the first edge loads the preset, and the first pulse appears at edge n+1.
- R7: In divide-by-10 000 mode `jam_i` has no effect, and pulses are exactly 10 000 cycles apart.
- R8: Preset values are clamped on load. D1 is clamped to M−1 when it is not below M. A decade digit above 9 is loaded as 9.
- R9: `out_o` is low while `rst_n_i` is low, and stays low after reset until the first terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock being divided |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| jam_i | input | 16 | Preset word loaded at every terminal count |
| sel_i | input | 3 | Mode select |
| latch_i | input | 1 | High: hold output after a pulse (timer mode) |
| out_o | output | 1 | Divided output pulse |

## Verification
A wrong modulus, a bad borrow between sections or a misrouted preset field changes the spacing between output pulses. It shows up at the port no later than the second pulse after the mode is applied. The bench therefore measures two quantities: the edge count from mode entry to the first pulse, and the edge count between the first and second pulses. A decade that leaves the BCD range would lengthen one period by a multiple of the weight of the digits below it. Timer-hold and pulse-width faults appear within one cycle of a pulse or of the latch release.

// File: rtl/modn_pkg.sv
package modn_pkg;

  localparam int DIG_W   = 4;
  localparam int NUM_DEC = 3;
  localparam int TOP_W   = 3;
  localparam int JAM_W   = DIG_W * (NUM_DEC + 1);
  localparam int LOWW_W  = 3;

  typedef enum logic [2:0] {
    SEL_HOLD_A = 3'b000,
    SEL_DIV5   = 3'b001,
    SEL_DIV10K = 3'b010,
    SEL_DIV10  = 3'b011,
    SEL_HOLD_B = 3'b100,
    SEL_DIV8   = 3'b101,
    SEL_DIV4   = 3'b110,
    SEL_DIV2   = 3'b111
  } sel_e;

  typedef struct packed {
    logic              hold;     // master-preset state
    logic              fixed;    // divide-by-10 000, presets ignored
    logic [DIG_W-1:0]  modulus;  // low-section modulus
    logic [LOWW_W-1:0] low_w;    // preset bits given to the low digit
  } mode_cfg_t;

  function automatic logic [DIG_W-1:0] bcd_clamp(input logic [DIG_W-1:0] d);
    return (d > DIG_W'(9)) ? DIG_W'(9) : d;
  endfunction

endpackage

// File: rtl/modn_rst_sync.sv
module modn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/modn_mode_decode.sv
module modn_mode_decode
  import modn_pkg::*;
(
  input  logic [2:0] sel_i,
  output mode_cfg_t  cfg_o
);
  always_comb begin
    cfg_o         = '0;
    cfg_o.modulus = DIG_W'(10);
    cfg_o.low_w   = LOWW_W'(4);
    case (sel_e'(sel_i))
      SEL_DIV2:   begin cfg_o.modulus = DIG_W'(2);  cfg_o.low_w = LOWW_W'(1); end
      SEL_DIV4:   begin cfg_o.modulus = DIG_W'(4);  cfg_o.low_w = LOWW_W'(2); end
      SEL_DIV5:   begin cfg_o.modulus = DIG_W'(5);  cfg_o.low_w = LOWW_W'(3); end
      SEL_DIV8:   begin cfg_o.modulus = DIG_W'(8);  cfg_o.low_w = LOWW_W'(3); end
      SEL_DIV10:  begin cfg_o.modulus = DIG_W'(10); cfg_o.low_w = LOWW_W'(4); end
      SEL_DIV10K: begin cfg_o.modulus = DIG_W'(10); cfg_o.low_w = LOWW_W'(4); cfg_o.fixed = 1'b1; end
      default:    cfg_o.hold = 1'b1;
    endcase
  end
endmodule

// File: rtl/modn_preset_map.sv
module modn_preset_map
  import modn_pkg::*;
(
  input  logic [JAM_W-1:0]         jam_i,
  input  mode_cfg_t                cfg_i,
  output logic [DIG_W-1:0]         low_o,
  output logic [NUM_DEC*DIG_W-1:0] dec_o,
  output logic [TOP_W-1:0]         top_o
);
  logic [DIG_W-1:0] nib0;
  logic [DIG_W-1:0] low_mask;
  logic [DIG_W-1:0] low_raw;
  logic [DIG_W-1:0] top_raw;

  assign nib0     = jam_i[DIG_W-1:0];
  assign low_mask = DIG_W'((1 << cfg_i.low_w) - 1);
  assign low_raw  = nib0 & low_mask;
  assign top_raw  = nib0 >> cfg_i.low_w;

  always_comb begin
    if (cfg_i.fixed) begin
      low_o = '0;
      top_o = TOP_W'(1);
    end else begin
      low_o = (low_raw >= cfg_i.modulus) ? (cfg_i.modulus - DIG_W'(1)) : low_raw;
      top_o = top_raw[TOP_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
    assign dec_o[g*DIG_W +: DIG_W] =
      cfg_i.fixed ? '0 : bcd_clamp(jam_i[(g+1)*DIG_W +: DIG_W]);
  end
endmodule

// File: rtl/modn_decade_chain.sv
module modn_decade_chain #(
  parameter int N = 3,
  parameter int W = 4
) (
  input  logic [N*W-1:0] cur_i,
  input  logic           borrow_i,
  output logic [N*W-1:0] nxt_o,
  output logic           borrow_o,
  output logic           zero_o
);
  logic [N:0] borrow;
  assign borrow[0] = borrow_i;

  for (genvar g = 0; g < N; g++) begin : g_stage
    logic [W-1:0] dig;
    assign dig = cur_i[g*W +: W];
    always_comb begin
      if (!borrow[g]) begin
        nxt_o[g*W +: W] = dig;
        borrow[g+1]     = 1'b0;
      end else if (dig == '0) begin
        nxt_o[g*W +: W] = W'(9);
        borrow[g+1]     = 1'b1;
      end else begin
        nxt_o[g*W +: W] = dig - W'(1);
        borrow[g+1]     = 1'b0;
      end
    end
  end

  assign borrow_o = borrow[N];
  assign zero_o   = ~|cur_i;
endmodule

// File: rtl/modn_divider.sv
module modn_divider
  import modn_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [JAM_W-1:0] jam_i,
  input  logic [2:0]       sel_i,
  input  logic             latch_i,
  output logic             out_o
);
  logic rst_n_s;
  mode_cfg_t cfg;

  logic [DIG_W-1:0]         low_pre, low_q, low_d, low_dn;
  logic [NUM_DEC*DIG_W-1:0] dec_pre, dec_q, dec_d, dec_dn;
  logic [TOP_W-1:0]         top_pre, top_q, top_d, top_dn;
  logic armed_q, armed_d, out_q, out_d;
  logic low_borrow, dec_borrow, dec_zero, term, load_en, count_en, pulse_d;

  modn_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_i),
    .rst_n_o(rst_n_s)
  );

  modn_mode_decode u_decode (
    .sel_i(sel_i),
    .cfg_o(cfg)
  );

  modn_preset_map u_preset (
    .jam_i(jam_i),
    .cfg_i(cfg),
    .low_o(low_pre),
    .dec_o(dec_pre),
    .top_o(top_pre)
  );

  // Low section: mod-M down count, borrow into the decades on wrap
  assign low_borrow = (low_q == '0);
  assign low_dn     = low_borrow ? (cfg.modulus - DIG_W'(1)) : (low_q - DIG_W'(1));

  modn_decade_chain #(.N(NUM_DEC), .W(DIG_W)) u_chain (
    .cur_i   (dec_q),
    .borrow_i(low_borrow),
    .nxt_o   (dec_dn),
    .borrow_o(dec_borrow),
    .zero_o  (dec_zero)
  );

  assign top_dn = dec_borrow ? (top_q - TOP_W'(1)) : top_q;

  // Terminal count: composite value has reached one (or less)
  assign term     = dec_zero & (top_q == '0) & (low_q <= DIG_W'(1));
  assign load_en  = cfg.hold | ~armed_q | term;
  assign count_en = ~load_en;
  assign pulse_d  = ~cfg.hold & armed_q & term;

  always_comb begin
    low_d   = low_q;
    dec_d   = dec_q;
    top_d   = top_q;
    if (load_en) begin
      low_d = low_pre;
      dec_d = dec_pre;
      top_d = top_pre;
    end else if (count_en) begin
      low_d = low_dn;
      dec_d = dec_dn;
      top_d = top_dn;
    end
    armed_d = ~cfg.hold;
    out_d   = ~cfg.hold & (pulse_d | (latch_i & out_q));
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      low_q   <= '0;
      dec_q   <= '0;
      top_q   <= '0;
      armed_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      low_q   <= low_d;
      dec_q   <= dec_d;
      top_q   <= top_d;
      armed_q <= armed_d;
      out_q   <= out_d;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/modn_divider_chk.sv
module modn_divider_chk
  import modn_pkg::*;
(
  input logic                     clk_i,
  input logic                     rst_n_i,
  input logic [2:0]               sel_i,
  input logic                     latch_i,
  input logic                     out_o,
  input logic [NUM_DEC*DIG_W-1:0] dec_q
);
  logic sel_hold;
  logic dec_legal;

  assign sel_hold = (sel_i == 3'b000) || (sel_i == 3'b100);

  always_comb begin
    dec_legal = 1'b1;
    for (int i = 0; i < NUM_DEC; i++) begin
      if (dec_q[i*DIG_W +: DIG_W] > DIG_W'(9)) dec_legal = 1'b0;
    end
  end

  // R6: master-preset codes keep the output low
  p_preset_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    sel_hold |=> !out_o);

  // R4: a fresh pulse lasts one cycle when latch is low
  p_one_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ($rose(out_o) && !latch_i && !sel_hold) |=> !out_o);

  // R5: timer hold keeps the output high while latch stays high
  p_timer_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (out_o && latch_i && !sel_hold) |=> out_o);

  // R8: decade digits never leave the BCD range
  p_bcd_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    dec_legal);

  // R9: output low while reset is asserted
  always @(negedge clk_i) begin
    if (!rst_n_i) begin
      p_reset_low_r9: assert (!out_o);
    end
  end
endmodule

bind modn_divider modn_divider_chk u_chk (
  .clk_i  (clk_i),
  .rst_n_i(rst_n_i),
  .sel_i  (sel_i),
  .latch_i(latch_i),
  .out_o  (out_o),
  .dec_q  (dec_q)
);

// File: tb/modn_divider_bench.sv
module modn_divider_bench;

  logic        clk_i = 1'b0;
  logic        rst_n_i;
  logic [15:0] jam_i;
  logic [2:0]  sel_i;
  logic        latch_i;
  logic        out_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk_i = ~clk_i;

  modn_divider u_modn_divider (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_i),
    .jam_i  (jam_i),
    .sel_i  (sel_i),
    .latch_i(latch_i),
    .out_o  (out_o)
  );

  localparam int NV = 10;
  localparam logic [2:0] V_SEL [NV] = '{
    3'b001,  // R1 M=5, digits 1,6,9,5 low 4
    3'b101,  // R1 M=8, digits 1,5,4,7 low 6
    3'b111,  // R3 M=2, top 7, decades 9, low 1
    3'b010,  // R7 fixed ten thousand, jam ignored
    3'b011,  // R8 M=10, every nibble F clamped
    3'b001,  // R8 M=5, low 7 clamped to 4
    3'b110,  // R3 M=4, top 3, low 2
    3'b101,  // R1 minimum n
    3'b011,  // R8 decade A clamped to 9
    3'b110   // R2 M=4 small ratio
  };
  localparam logic [15:0] V_JAM [NV] = '{
    16'h695C, 16'h547E, 16'hFFFF, 16'h1234, 16'hFFFF,
    16'h0017, 16'h000E, 16'h0003, 16'h0A00, 16'h0101
  };
  localparam int V_N [NV] = '{
    8479, 12382, 15999, 10000, 9999, 9, 12002, 3, 900, 41
  };

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  task automatic edges_to_pulse(output int edges);
    edges = 0;
    do begin
      @(posedge clk_i); #1;
      edges++;
    end while (!out_o && edges < 20000);
  endtask

  initial begin
    repeat (195000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int e;
    int highs;
    rst_n_i = 1'b0;
    sel_i   = 3'b000;
    jam_i   = 16'h0000;
    latch_i = 1'b0;

    // R9: reset state
    repeat (3) @(posedge clk_i); #1;
    check("R9 out during reset", out_o, 0);
    @(negedge clk_i) rst_n_i = 1'b1;
    repeat (4) @(posedge clk_i); #1;
    check("R9 out after reset", out_o, 0);

    // R6: both master-preset codes hold the output low
    @(negedge clk_i) begin sel_i = 3'b000; jam_i = 16'h0003; end
    highs = 0;
    for (int i = 0; i < 30; i++) begin @(posedge clk_i); #1; highs += out_o; end
    check("R6 code 000 quiet", highs, 0);
    @(negedge clk_i) sel_i = 3'b100;
    highs = 0;
    for (int i = 0; i < 30; i++) begin @(posedge clk_i); #1; highs += out_o; end
    check("R6 code 100 quiet", highs, 0);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i) begin sel_i = 3'b000; jam_i = V_JAM[v]; end
      repeat (2) @(negedge clk_i);
      sel_i = V_SEL[v];
      edges_to_pulse(e);
      check($sformatf("R6 first pulse vec %0d", v), e, V_N[v] + 1);
      edges_to_pulse(e);
      check($sformatf("R1 period vec %0d", v), e, V_N[v]);
      @(posedge clk_i); #1;
      check($sformatf("R4 width vec %0d", v), out_o, 0);
    end

    // R5: timer hold with n = 5 (M=8, low digit 5)
    @(negedge clk_i) begin sel_i = 3'b000; jam_i = 16'h0005; latch_i = 1'b1; end
    repeat (2) @(negedge clk_i);
    sel_i = 3'b101;
    edges_to_pulse(e);
    check("R5 first pulse", e, 6);
    highs = 0;
    for (int i = 1; i <= 22; i++) begin @(posedge clk_i); #1; highs += out_o; end
    check("R5 held high cycles", highs, 22);
    latch_i = 1'b0;
    @(posedge clk_i); #1;
    check("R5 release drops output", out_o, 0);
    @(posedge clk_i); #1;
    check("R5 still low", out_o, 0);
    @(posedge clk_i); #1;
    check("R5 count continued during hold", out_o, 1);
    @(posedge clk_i); #1;
    check("R4 width after release", out_o, 0);

    summary();
  end

endmodule